// File: doc/BRIEF.md
# Predecode Chunk Reuse Matcher

This block holds one cached record of the raw bytes that made up a previously decoded variable-length instruction starting at one address. The record keeps up to three fetch chunks of eight bytes each, a byte-lane mask for every stored chunk, the byte offset at which the instruction ended inside its last chunk, and a flag saying the record describes a fully decoded instruction. When the front end comes back to the same start address, it starts a lookup and feeds fetched chunks in order. The block compares each chunk with the stored one under that chunk's mask. It then answers with one of three results: ask for the next chunk, report a hit with the offset where fetching resumes, or report a miss so that full decode restarts at the start offset.

When the record is not valid at the start of a lookup, the stored chunk list is emptied, and every chunk that arrives is appended for the full decoder's benefit. Once decode completes, a learn request supplies the start offset and the final end offset. The block then derives the byte masks, trims the stored chunks to the instruction's own bytes, and marks the record valid. A miss rewrites the mismatching chunk, drops everything after it, and clears the valid flag. Any chunks that follow the miss are appended again.

Top module: `pdc_chunk_match`

## Requirements
- R1: After reset, hit, miss, need_more and fetch_again are 0, entry_valid is 0 and entry_chunks is 0.
- R2: A lookup_start while entry_valid is 0 sets entry_chunks to 0. Each following chunk_valid appends the chunk and raises entry_chunks by one, up to a maximum of 3. Further chunks are dropped. Appending raises none of hit, miss or need_more.
- R3: With entry_valid at 1, a lookup compares each fetched chunk with the stored chunk at the current index, but only in the byte lanes that the stored mask enables. Lane j of a chunk is chunk_data bits [8j+7:8j], and lane 0 is the lowest address.
- R4: A matching chunk that is not the last stored chunk raises need_more for one cycle and advances the index by one.
- R5: A matching last chunk raises hit for one cycle and sets resume_off to the learned end offset. fetch_again is 1 exactly when that offset equals 8.
- R6: A mismatching chunk raises miss for one cycle, sets restart_off to the lookup's start offset and clears entry_valid. It stores the fetched chunk at the current index, sets entry_chunks to index+1 and resets the index to 0. Chunks that arrive afterwards are appended.
- R7: learn_valid sets entry_valid. The instruction length is learn_end − learn_start + (entry_chunks − 1) × 8. Chunk 0's mask enables lanes from learn_start upward, and every later chunk's mask enables lanes from 0 upward. Each chunk covers min(8, first lane + remaining length) minus its first lane, and the bytes it covers are subtracted from the remaining length.
- R8: Learning ANDs each stored chunk with its own mask. Bytes outside the masks therefore never affect a later comparison.
- R9: After learning, every stored chunk has a nonzero mask, and the masks together enable exactly as many lanes as the instruction length.
- R10: At most one of hit, miss and need_more is 1 in any cycle. Each follows the chunk_valid cycle by one clock. A chunk_valid outside a lookup or an append is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_start | input | 1 | Begin a lookup for the cached start address |
| lookup_off | input | 3 | Start address modulo 8 for this lookup |
| chunk_valid | input | 1 | A fetched chunk is present on chunk_data |
| chunk_data | input | 64 | Fetched chunk, lane 0 in bits [7:0] |
| learn_valid | input | 1 | Full decode finished; build masks |
| learn_start | input | 3 | Start offset in the first chunk |
| learn_end | input | 4 | End offset in the last chunk, 1 to 8 |
| hit | output | 1 | Cached instruction matched |
| miss | output | 1 | Mismatch; restart full decode |
| need_more | output | 1 | Matched so far; send the next chunk |
| resume_off | output | 4 | Byte offset at which fetching resumes after a hit |
| fetch_again | output | 1 | Hit ended at the chunk boundary; a new fetch is needed |
| restart_off | output | 3 | Start offset at which full decode restarts after a miss |
| entry_valid | output | 1 | The record holds a decoded instruction |
| entry_chunks | output | 2 | Number of stored chunks |

## Verification
The matcher is driven with exact replays of the learned bytes. It is also driven with chunks altered in a single byte lane just outside the mask edge and just inside it, on the first chunk, on a middle chunk and on the last chunk. An outside change must still hit and an inside change must miss, which tells a correctly placed mask from one that is shifted by a lane or lost. Three entry shapes are covered: a two-chunk instruction starting at offset 5, a single chunk ending exactly at the boundary, and a fifteen-byte instruction spread over three chunks. Between them they separate the fetch_again case and the first-chunk start rule from the later-chunk start rule. Replaying both the old and the new chunk after a miss shows whether the mismatching chunk was really replaced.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    PM_IDLE   = 2'd0,
    PM_MATCH  = 2'd1,
    PM_APPEND = 2'd2
  } pdc_mode_e;
endpackage

// File: rtl/pdc_lane_mask.sv
// Byte-lane masks for every chunk slot. A lane is enabled when its global
// byte position lies between the start offset and the end of the instruction.
module pdc_lane_mask #(
  parameter int CB = 8,
  parameter int MC = 3,
  parameter int SW = 3,
  parameter int EW = 4,
  parameter int CW = 2
) (
  input  logic [SW-1:0]          start_off,
  input  logic [EW-1:0]          end_off,
  input  logic [CW-1:0]          n_chunks,
  output logic [MC-1:0][CB-1:0]  lanes
);
  localparam int PW = $clog2(MC*CB+1) + 1;

  logic [PW-1:0] stop_pos;

  always_comb begin
    if (n_chunks == '0) stop_pos = '0;
    else stop_pos = PW'(n_chunks - CW'(1)) * PW'(CB) + PW'(end_off);
  end

  for (genvar k = 0; k < MC; k++) begin : g_chunk
    for (genvar j = 0; j < CB; j++) begin : g_lane
      assign lanes[k][j] = (PW'(k*CB + j) >= PW'(start_off)) &&
                           (PW'(k*CB + j) <  stop_pos);
    end
  end
endmodule

// File: rtl/pdc_chunk_cmp.sv
// Masked comparison of a fetched chunk against a trimmed stored chunk.
module pdc_chunk_cmp #(
  parameter int CB = 8
) (
  input  logic [CB*8-1:0] fetched,
  input  logic [CB*8-1:0] stored,
  input  logic [CB-1:0]   lanes,
  output logic            same
);
  logic [CB*8-1:0] bit_mask;

  for (genvar j = 0; j < CB; j++) begin : g_expand
    assign bit_mask[8*j +: 8] = {8{lanes[j]}};
  end

  assign same = ((fetched & bit_mask) == stored);
endmodule

// File: rtl/pdc_chunk_match.sv
module pdc_chunk_match
  import pdc_pkg::*;
#(
  parameter int CB = 8,
  parameter int MC = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lookup_start,
  input  logic [$clog2(CB)-1:0]       lookup_off,
  input  logic                        chunk_valid,
  input  logic [CB*8-1:0]             chunk_data,
  input  logic                        learn_valid,
  input  logic [$clog2(CB)-1:0]       learn_start,
  input  logic [$clog2(CB+1)-1:0]     learn_end,
  output logic                        hit,
  output logic                        miss,
  output logic                        need_more,
  output logic [$clog2(CB+1)-1:0]     resume_off,
  output logic                        fetch_again,
  output logic [$clog2(CB)-1:0]       restart_off,
  output logic                        entry_valid,
  output logic [$clog2(MC+1)-1:0]     entry_chunks
);
  localparam int SW = $clog2(CB);
  localparam int EW = $clog2(CB+1);
  localparam int CW = $clog2(MC+1);
  localparam int LW = $clog2(MC*CB+1) + 1;
  localparam int DW = CB*8;

  // State registers and their next values
  logic [MC-1:0][DW-1:0] chunk_q, chunk_d;
  logic [MC-1:0][CB-1:0] mask_q, mask_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [CW-1:0]         idx_q, idx_d;
  logic                  valid_q, valid_d;
  logic [EW-1:0]         end_q, end_d;
  logic [SW-1:0]         base_q, base_d;
  pdc_mode_e             mode_q, mode_d;
  logic                  hit_q, hit_d, miss_q, miss_d, more_q, more_d;
  logic [EW-1:0]         resume_q, resume_d;
  logic                  again_q, again_d;
  logic [SW-1:0]         restart_q, restart_d;
  logic                  learn_q, learn_d;
  logic [LW-1:0]         len_q, len_d;

  logic [MC-1:0][CB-1:0] lanes_new;
  logic [MC-1:0][DW-1:0] trim_bits;
  logic                  same;

  pdc_lane_mask #(.CB(CB), .MC(MC), .SW(SW), .EW(EW), .CW(CW)) u_mask (
    .start_off (learn_start),
    .end_off   (learn_end),
    .n_chunks  (cnt_q),
    .lanes     (lanes_new)
  );

  for (genvar k = 0; k < MC; k++) begin : g_trim
    for (genvar j = 0; j < CB; j++) begin : g_lane
      assign trim_bits[k][8*j +: 8] = {8{lanes_new[k][j]}};
    end
  end

  pdc_chunk_cmp #(.CB(CB)) u_cmp (
    .fetched (chunk_data),
    .stored  (chunk_q[idx_q]),
    .lanes   (mask_q[idx_q]),
    .same    (same)
  );

  always_comb begin
    chunk_d   = chunk_q;
    mask_d    = mask_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    valid_d   = valid_q;
    end_d     = end_q;
    base_d    = base_q;
    mode_d    = mode_q;
    hit_d     = 1'b0;
    miss_d    = 1'b0;
    more_d    = 1'b0;
    learn_d   = 1'b0;
    resume_d  = resume_q;
    again_d   = again_q;
    restart_d = restart_q;
    len_d     = len_q;
    if (lookup_start) begin
      idx_d  = '0;
      base_d = lookup_off;
      if (valid_q) begin
        mode_d = PM_MATCH;
      end else begin
        mode_d = PM_APPEND;
        cnt_d  = '0;
      end
    end else if (learn_valid) begin
      for (int k = 0; k < MC; k++) chunk_d[k] = chunk_q[k] & trim_bits[k];
      mask_d  = lanes_new;
      end_d   = learn_end;
      valid_d = 1'b1;
      mode_d  = PM_IDLE;
      learn_d = 1'b1;
      len_d   = LW'(learn_end) - LW'(learn_start) +
                LW'(cnt_q - CW'(1)) * LW'(CB);
    end else if (chunk_valid) begin
      case (mode_q)
        PM_APPEND: begin
          if (cnt_q < CW'(MC)) begin
            chunk_d[cnt_q] = chunk_data;
            cnt_d          = cnt_q + CW'(1);
          end
        end
        PM_MATCH: begin
          if (!same) begin
            chunk_d[idx_q] = chunk_data;
            cnt_d          = idx_q + CW'(1);
            valid_d        = 1'b0;
            idx_d          = '0;
            miss_d         = 1'b1;
            restart_d      = base_q;
            mode_d         = PM_APPEND;
          end else if (idx_q == cnt_q - CW'(1)) begin
            hit_d    = 1'b1;
            resume_d = end_q;
            again_d  = (end_q == EW'(CB));
            mode_d   = PM_IDLE;
          end else begin
            idx_d  = idx_q + CW'(1);
            more_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_q   <= '0;
      mask_q    <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      valid_q   <= 1'b0;
      end_q     <= '0;
      base_q    <= '0;
      mode_q    <= PM_IDLE;
      hit_q     <= 1'b0;
      miss_q    <= 1'b0;
      more_q    <= 1'b0;
      resume_q  <= '0;
      again_q   <= 1'b0;
      restart_q <= '0;
      learn_q   <= 1'b0;
      len_q     <= '0;
    end else begin
      chunk_q   <= chunk_d;
      mask_q    <= mask_d;
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      valid_q   <= valid_d;
      end_q     <= end_d;
      base_q    <= base_d;
      mode_q    <= mode_d;
      hit_q     <= hit_d;
      miss_q    <= miss_d;
      more_q    <= more_d;
      resume_q  <= resume_d;
      again_q   <= again_d;
      restart_q <= restart_d;
      learn_q   <= learn_d;
      len_q     <= len_d;
    end
  end

  assign hit          = hit_q;
  assign miss         = miss_q;
  assign need_more    = more_q;
  assign resume_off   = resume_q;
  assign fetch_again  = again_q;
  assign restart_off  = restart_q;
  assign entry_valid  = valid_q;
  assign entry_chunks = cnt_q;

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_q, miss_q, more_q}));

  // R6
  miss_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |-> !valid_q && (mode_q == PM_APPEND));

  // R5
  hit_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (again_q == (resume_q == EW'(CB))) && valid_q);

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_MATCH) |-> (idx_q < cnt_q));

  // R9
  mask_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    learn_q |-> ($countones(mask_q) == int'(len_q)));

  for (genvar k = 0; k < MC; k++) begin : g_nz
    // R9
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (learn_q && (CW'(k) < cnt_q)) |-> (mask_q[k] != '0));
  end
endmodule

// File: tb/tb_pdc_chunk_match.sv
`timescale 1ns/1ps
module tb_pdc_chunk_match;
  logic        clk, rst_n;
  logic        lookup_start, chunk_valid, learn_valid;
  logic [2:0]  lookup_off, learn_start;
  logic [3:0]  learn_end;
  logic [63:0] chunk_data;
  logic        hit, miss, need_more, fetch_again, entry_valid;
  logic [3:0]  resume_off;
  logic [2:0]  restart_off;
  logic [1:0]  entry_chunks;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  pdc_chunk_match dut (
    .clk(clk), .rst_n(rst_n),
    .lookup_start(lookup_start), .lookup_off(lookup_off),
    .chunk_valid(chunk_valid), .chunk_data(chunk_data),
    .learn_valid(learn_valid), .learn_start(learn_start), .learn_end(learn_end),
    .hit(hit), .miss(miss), .need_more(need_more),
    .resume_off(resume_off), .fetch_again(fetch_again),
    .restart_off(restart_off), .entry_valid(entry_valid),
    .entry_chunks(entry_chunks)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [63:0] A0 = 64'h1122334455667788;
  localparam logic [63:0] A1 = 64'h99AABBCCDDEEFF01;
  localparam logic [63:0] B0 = 64'h0F1E2D3C4B5A6978;
  localparam logic [63:0] C0 = 64'hC0C1C2C3C4C5C6C7;
  localparam logic [63:0] D0 = 64'hD0D1D2D3D4D5D6D7;
  localparam logic [63:0] D1 = 64'hE0E1E2E3E4E5E6E7;
  localparam logic [63:0] D2 = 64'hF0F1F2F3F4F5F6F7;
  localparam logic [63:0] D3 = 64'h0102030405060708;

  function automatic logic [63:0] flip(logic [63:0] v, int lane);
    return v ^ (64'hFF << (8*lane));
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_lookup(logic [2:0] off);
    @(negedge clk);
    lookup_start = 1'b1; lookup_off = off;
    @(negedge clk);
    lookup_start = 1'b0;
  endtask

  task automatic learn(logic [2:0] s, logic [3:0] e);
    @(negedge clk);
    learn_valid = 1'b1; learn_start = s; learn_end = e;
    @(negedge clk);
    learn_valid = 1'b0;
  endtask

  // Sends one chunk and checks the result flags one clock later.
  task automatic send(string req, logic [63:0] d, bit eh, bit em, bit en);
    @(negedge clk);
    chunk_valid = 1'b1; chunk_data = d;
    @(negedge clk);
    chunk_valid = 1'b0;
    chk(req, "flags{hit,miss,more}", {hit, miss, need_more}, {eh, em, en});
  endtask

  task automatic t_reset;
    chk("R1", "flags", {hit, miss, need_more, fetch_again}, 4'b0);
    chk("R1", "entry_valid", entry_valid, 0);
    chk("R1", "entry_chunks", entry_chunks, 0);
  endtask

  task automatic t_first_fill;
    start_lookup(3'd5);
    chk("R2", "chunks cleared", entry_chunks, 0);
    send("R2", A0, 0, 0, 0);
    send("R2", A1, 0, 0, 0);
    chk("R2", "chunks after append", entry_chunks, 2);
    learn(3'd5, 4'd4);
    chk("R7", "entry_valid", entry_valid, 1);
  endtask

  task automatic t_exact_hit;
    start_lookup(3'd5);
    send("R4", A0, 0, 0, 1);
    send("R5", A1, 1, 0, 0);
    chk("R5", "resume_off", resume_off, 4);
    chk("R5", "fetch_again", fetch_again, 0);
  endtask

  task automatic t_outside_lanes;
    start_lookup(3'd5);
    send("R8", flip(A0, 4), 0, 0, 1);
    send("R8", flip(A1, 4), 1, 0, 0);
  endtask

  task automatic t_miss_second;
    start_lookup(3'd5);
    send("R3", A0, 0, 0, 1);
    send("R3", flip(A1, 3), 0, 1, 0);
    chk("R6", "restart_off", restart_off, 5);
    chk("R6", "entry_valid", entry_valid, 0);
    chk("R6", "entry_chunks", entry_chunks, 2);
    learn(3'd5, 4'd4);
    start_lookup(3'd5);
    send("R6", A0, 0, 0, 1);
    send("R6", flip(A1, 3), 1, 0, 0);
    start_lookup(3'd5);
    send("R6", A0, 0, 0, 1);
    send("R6", A1, 0, 1, 0);
    learn(3'd5, 4'd4);
  endtask

  task automatic t_miss_first;
    start_lookup(3'd5);
    send("R7", flip(A0, 5), 0, 1, 0);
    chk("R6", "entry_chunks", entry_chunks, 1);
    chk("R6", "restart_off", restart_off, 5);
    send("R6", B0, 0, 0, 0);
    chk("R6", "append after miss", entry_chunks, 2);
  endtask

  task automatic t_full_chunk;
    start_lookup(3'd0);
    chk("R2", "chunks cleared", entry_chunks, 0);
    send("R2", C0, 0, 0, 0);
    learn(3'd0, 4'd8);
    start_lookup(3'd0);
    send("R5", C0, 1, 0, 0);
    chk("R5", "resume_off", resume_off, 8);
    chk("R5", "fetch_again", fetch_again, 1);
    start_lookup(3'd0);
    send("R7", flip(C0, 7), 0, 1, 0);
    chk("R6", "restart_off", restart_off, 0);
  endtask

  task automatic t_three_chunks;
    start_lookup(3'd7);
    send("R2", D0, 0, 0, 0);
    send("R2", D1, 0, 0, 0);
    send("R2", D2, 0, 0, 0);
    send("R2", D3, 0, 0, 0);
    chk("R2", "saturated chunks", entry_chunks, 3);
    learn(3'd7, 4'd6);
    start_lookup(3'd7);
    send("R7", flip(D0, 6), 0, 0, 1);
    send("R4", D1, 0, 0, 1);
    send("R7", flip(D2, 6), 1, 0, 0);
    chk("R5", "resume_off", resume_off, 6);
    chk("R5", "fetch_again", fetch_again, 0);
    start_lookup(3'd7);
    send("R9", D0, 0, 0, 1);
    send("R9", flip(D1, 0), 0, 1, 0);
    chk("R6", "entry_chunks", entry_chunks, 2);
  endtask

  task automatic t_idle_ignored;
    start_lookup(3'd2);
    send("R2", C0, 0, 0, 0);
    learn(3'd2, 4'd5);
    send("R10", D0, 0, 0, 0);
    chk("R10", "entry_valid", entry_valid, 1);
    chk("R10", "entry_chunks", entry_chunks, 1);
    start_lookup(3'd2);
    send("R9", flip(C0, 1), 1, 0, 0);
    start_lookup(3'd2);
    send("R9", flip(C0, 4), 0, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; lookup_start = 1'b0; lookup_off = '0;
    chunk_valid = 1'b0; chunk_data = '0;
    learn_valid = 1'b0; learn_start = '0; learn_end = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_fill;
    t_exact_hit;
    t_outside_lanes;
    t_miss_second;
    t_miss_first;
    t_full_chunk;
    t_three_chunks;
    t_idle_ignored;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule